// File: doc/BRIEF.md
# Dual Programmable Clock Output Generator

This block derives two independent clock waveforms from the bus clock. Each waveform is set by two small counts: a terminal count that fixes the period and a duty count that fixes how long the output stays high. Both counts for both channels, together with a per-channel enable, live in one shared 32-bit control word. Software writes that word through a simple write strobe and can read it back.

When a channel is enabled, its waveform takes over one fixed general-purpose output pin: channel 0 drives pin 14 and channel 1 drives pin 15. The normal output value for that pin is replaced. When the channel is disabled, the pin goes back to the normal output value. All other pins always pass the normal output values straight through.

Reprogramming is safe while a channel runs. New counts are taken only at the next period boundary. A freshly enabled channel always begins with a full high phase. With a 66 MHz bus clock, a terminal count of 1 gives 33 MHz and a terminal count of 14 gives about 4.4 MHz.

Top module: `clkgen_dual`

## Requirements
- R1: After reset the control word reads zero, and every pin equals the matching bit of `gpio_out_i`.
- R2: A write loads the control word, and the new value is visible on `cfg_rdata_o` one cycle later. The field positions are as follows. For channel 0, the duty count is bits [3:0], the terminal count is bits [7:4] and the enable is bit 8. For channel 1, the duty count is bits [19:16], the terminal count is bits [23:20] and the enable is bit 24. All other bits read as zero, so the writable mask is 0x01FF01FF.
- R3: While a channel runs with duty count DC below terminal count TC, its output has a period of TC+1 bus cycles. It is high for the first DC+1 cycles of each period and low for the rest.
- R4: While a channel runs with DC greater than or equal to TC, its output stays high. This includes TC = 0.
- R5: The enable bit becomes visible in the control word one cycle after the write. One cycle after that, the channel starts. Its pin switches from the normal output value directly to a high output, at the start of a fresh period.
- R6: A TC or DC change written while a channel runs does not alter the period in progress. The new values apply from the next period boundary onward.
- R7: The enable bit clears one cycle after the write. One cycle after that, the channel stops, its counter is cleared, and its pin returns to the normal output value.
- R8: Pins 0 to 13 always equal `gpio_out_i`. Pin 14 and pin 15 equal `gpio_out_i` whenever their channel is not running.
- R9: The two channels run independently. Programming one channel never changes the waveform or the pin of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which is also the divider source |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Current control word, with reserved bits reading as zero |
| gpio_out_i | input | 16 | Normal output values for the pins |
| pin_o | output | 16 | Pin values after the clock override |

## Verification
Two functions can fall in the same cycle, and this is where the risk lies. A control-word write can land in the very cycle a channel reaches its period boundary and reloads its counts. In that case the reload must use the word as it stood before the write, and the new counts must wait one full further period.

This case is provoked in two ways. A directed sequence writes in the middle of a slow period. Thousands of random writes, made at random cycles with random enables and counts on both channels, are also applied, so many of them coincide with boundaries, with enables and with disables.

Every cycle, a bench model built from the requirements predicts both pins and the readback. Any single-cycle slip in the reload or in the start and stop shows up as a pin mismatch.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int unsigned CNT_W       = 4;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned NUM_CLK     = 2;
    localparam int unsigned SLOT_STRIDE = 16;
    localparam int unsigned DC_OFS      = 0;
    localparam int unsigned TC_OFS      = 4;
    localparam int unsigned EN_OFS      = 8;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] tc;
        logic [CNT_W-1:0] dc;
    } slot_cfg_t;

    typedef struct packed {
        logic             run;
        logic             wave;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tc;
        logic [CNT_W-1:0] dc;
    } div_state_t;

    function automatic logic [REG_W-1:0] field_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_CLK; k++) begin
            for (int b = 0; b < CNT_W; b++) begin
                m[k*SLOT_STRIDE + DC_OFS + b] = 1'b1;
                m[k*SLOT_STRIDE + TC_OFS + b] = 1'b1;
            end
            m[k*SLOT_STRIDE + EN_OFS] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    output slot_cfg_t [NUM_CLK-1:0]   cfg_o
);

    localparam logic [REG_W-1:0] FIELD_MASK = field_mask();

    typedef struct packed {
        logic [REG_W-1:0] word;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_i) begin
            reg_d.word = wdata_i & FIELD_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata_o = reg_q.word;

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_slot
        assign cfg_o[k].dc = reg_q.word[k*SLOT_STRIDE + DC_OFS +: CNT_W];
        assign cfg_o[k].tc = reg_q.word[k*SLOT_STRIDE + TC_OFS +: CNT_W];
        assign cfg_o[k].en = reg_q.word[k*SLOT_STRIDE + EN_OFS];
    end

endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_cfg_t cfg_i,
    output logic      wave_o,
    output logic      active_o
);

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cfg_i.en) begin
            // Stopped: counter held clear, pin handed back to the port value
            st_d.run  = 1'b0;
            st_d.wave = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.run || (st_q.cnt >= st_q.tc)) begin
            // Fresh start or period boundary: capture counts, begin high
            st_d.run  = 1'b1;
            st_d.cnt  = '0;
            st_d.tc   = cfg_i.tc;
            st_d.dc   = cfg_i.dc;
            st_d.wave = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.wave = (st_d.cnt <= st_q.dc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o   = st_q.wave;
    assign active_o = st_q.run;

endmodule

// File: rtl/clkgen_pinmux.sv
module clkgen_pinmux
    import clkgen_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 16,
    parameter int unsigned CLK_PIN_BASE = 14
) (
    input  logic [NUM_PINS-1:0] gpio_i,
    input  logic [NUM_CLK-1:0]  wave_i,
    input  logic [NUM_CLK-1:0]  active_i,
    output logic [NUM_PINS-1:0] pin_o
);

    always_comb begin
        pin_o = gpio_i;
        for (int k = 0; k < NUM_CLK; k++) begin
            if (active_i[k]) begin
                pin_o[CLK_PIN_BASE + k] = wave_i[k];
            end
        end
    end

endmodule

// File: rtl/clkgen_dual.sv
module clkgen_dual
    import clkgen_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 16,
    parameter int unsigned CLK_PIN_BASE = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_i,
    input  logic [REG_W-1:0]    cfg_wdata_i,
    output logic [REG_W-1:0]    cfg_rdata_o,
    input  logic [NUM_PINS-1:0] gpio_out_i,
    output logic [NUM_PINS-1:0] pin_o
);

    slot_cfg_t [NUM_CLK-1:0] slot_cfg;
    logic      [NUM_CLK-1:0] clk_wave;
    logic      [NUM_CLK-1:0] clk_active;

    clkgen_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .cfg_o   (slot_cfg)
    );

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_div
        clkgen_divider i_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (slot_cfg[k]),
            .wave_o   (clk_wave[k]),
            .active_o (clk_active[k])
        );
    end

    clkgen_pinmux #(
        .NUM_PINS     (NUM_PINS),
        .CLK_PIN_BASE (CLK_PIN_BASE)
    ) i_pinmux (
        .gpio_i   (gpio_out_i),
        .wave_i   (clk_wave),
        .active_i (clk_active),
        .pin_o    (pin_o)
    );

endmodule

// File: rtl/clkgen_dual_chk.sv
module clkgen_dual_chk
    import clkgen_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 16,
    parameter int unsigned CLK_PIN_BASE = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr,
    input logic [REG_W-1:0]    cfg_wdata,
    input logic [REG_W-1:0]    cfg_rdata,
    input logic [NUM_PINS-1:0] gpio_i,
    input logic [NUM_PINS-1:0] pin_o,
    input logic [NUM_CLK-1:0]  active,
    input logic [NUM_CLK-1:0]  wave
);

    localparam logic [REG_W-1:0] FIELD_MASK = field_mask();

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~FIELD_MASK) == '0); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & FIELD_MASK))); // R2

    AST_PLAIN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_o[CLK_PIN_BASE-1:0] == gpio_i[CLK_PIN_BASE-1:0]); // R8

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_ch
        AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(active[k]) |-> wave[k]); // R5

        AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_rdata[k*SLOT_STRIDE + EN_OFS] |=> active[k]); // R5

        AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_rdata[k*SLOT_STRIDE + EN_OFS] |=> !active[k]); // R7

        AST_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            !active[k] |-> (pin_o[CLK_PIN_BASE + k] == gpio_i[CLK_PIN_BASE + k])); // R8
    end

endmodule

bind clkgen_dual clkgen_dual_chk #(
    .NUM_PINS     (NUM_PINS),
    .CLK_PIN_BASE (CLK_PIN_BASE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr_i),
    .cfg_wdata (cfg_wdata_i),
    .cfg_rdata (cfg_rdata_o),
    .gpio_i    (gpio_out_i),
    .pin_o     (pin_o),
    .active    (clk_active),
    .wave      (clk_wave)
);

// File: tb/test_clkgen_dual.sv
module test_clkgen_dual;

    localparam logic [31:0] MASK = 32'h01FF_01FF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] gpio;
    logic [15:0] pins;

    always #2 clk = ~clk;

    clkgen_dual i_clkgen_dual (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .gpio_out_i  (gpio),
        .pin_o       (pins)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench-side expectation of the state after each rising edge
    logic [31:0] m_cfg;
    bit          m_run  [2];
    bit          m_wave [2];
    int          m_cnt  [2];
    int          m_tc   [2];
    int          m_dc   [2];
    string       tag_pin[2];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word(bit en0, int tc0, int dc0, bit en1, int tc1, int dc1);
        logic [31:0] w;
        w = '0;
        w[3:0]   = 4'(dc0);
        w[7:4]   = 4'(tc0);
        w[8]     = en0;
        w[19:16] = 4'(dc1);
        w[23:20] = 4'(tc1);
        w[24]    = en1;
        return w;
    endfunction

    function automatic logic [15:0] exp_pins(logic [15:0] g);
        logic [15:0] r;
        r = g;
        for (int k = 0; k < 2; k++) begin
            if (m_run[k]) r[14+k] = m_wave[k];
        end
        return r;
    endfunction

    function automatic void model_step(bit wr, logic [31:0] wd);
        for (int k = 0; k < 2; k++) begin
            int  base;
            bit  en;
            int  tc;
            int  dc;
            base = 16 * k;
            en   = m_cfg[base + 8];
            tc   = int'(m_cfg[base + 4 +: 4]);
            dc   = int'(m_cfg[base +: 4]);
            if (!en) begin
                m_run[k] = 0; m_wave[k] = 0; m_cnt[k] = 0;
            end else if (!m_run[k] || m_cnt[k] >= m_tc[k]) begin
                m_run[k] = 1; m_cnt[k] = 0; m_tc[k] = tc; m_dc[k] = dc; m_wave[k] = 1;
            end else begin
                m_cnt[k]  = m_cnt[k] + 1;
                m_wave[k] = (m_cnt[k] <= m_dc[k]);
            end
        end
        if (wr) m_cfg = wd & MASK;
    endfunction

    task automatic compare_now();
        logic [15:0] ep;
        ep = exp_pins(gpio);
        chk("R2", cfg_rdata, m_cfg);
        chk("R8", {18'b0, pins[13:0]}, {18'b0, ep[13:0]});
        for (int k = 0; k < 2; k++) begin
            chk(tag_pin[k], 32'(pins[14+k]), 32'(ep[14+k]));
        end
    endtask

    task automatic step(bit wr, logic [31:0] wd, logic [15:0] g);
        compare_now();
        cfg_wr    = wr;
        cfg_wdata = wd;
        gpio      = g;
        model_step(wr, wd);
        @(negedge clk);
    endtask

    initial begin
        int          hi;
        logic [19:0] got;
        logic [19:0] exp;
        int unsigned seed;
        int unsigned r;

        seed = 32'd20240611;
        r    = $urandom(seed);
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; gpio = 16'h5A5A;
        m_cfg = '0;
        for (int k = 0; k < 2; k++) begin
            m_run[k] = 0; m_wave[k] = 0; m_cnt[k] = 0; m_tc[k] = 0; m_dc[k] = 0;
        end
        tag_pin[0] = "R3";
        tag_pin[1] = "R9";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", cfg_rdata, 32'h0);
        chk("R1", {16'h0, pins}, {16'h0, 16'h5A5A});

        // R5 then R3: start channel 0 at the slowest standard rate
        step(1'b1, word(1, 14, 7, 0, 0, 0), 16'h0);
        chk("R5", 32'(pins[14]), 32'd0);
        step(1'b0, '0, 16'h0);
        chk("R5", 32'(pins[14]), 32'd1);
        hi = 0;
        for (int i = 0; i < 15; i++) begin
            hi += int'(pins[14]);
            step(1'b0, '0, 16'h0);
        end
        chk("R3", 32'(hi), 32'd8);
        chk("R3", 32'(pins[14]), 32'd1);

        // R6: reprogram to the fastest rate in the middle of a slow period
        tag_pin[0] = "R6";
        for (int i = 0; i < 20; i++) begin
            got[i] = pins[14];
            exp[i] = (i <= 7) ? 1'b1 : (i <= 14) ? 1'b0 : (((i - 15) % 2) == 0);
            step(i == 3, word(1, 1, 0, 0, 0, 0), 16'h0);
        end
        chk("R6", 32'(got), 32'(exp));

        // R4: duty count at or above terminal count holds the output high
        tag_pin[0] = "R4";
        step(1'b1, word(1, 3, 5, 0, 0, 0), 16'h0);
        repeat (3) step(1'b0, '0, 16'h0);
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            hi += int'(pins[14]);
            step(1'b0, '0, 16'h0);
        end
        chk("R4", 32'(hi), 32'd12);
        step(1'b1, word(1, 0, 0, 0, 0, 0), 16'h0);
        repeat (4) step(1'b0, '0, 16'h0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            hi += int'(pins[14]);
            step(1'b0, '0, 16'h0);
        end
        chk("R4", 32'(hi), 32'd10);

        // R7: disable hands the pin back two edges after the write edge
        tag_pin[0] = "R7";
        step(1'b1, word(0, 0, 0, 0, 0, 0), 16'h0);
        chk("R7", 32'(pins[14]), 32'd1);
        step(1'b0, '0, 16'h0);
        chk("R7", 32'(pins[14]), 32'd0);
        step(1'b0, '0, 16'h4000);
        chk("R7", 32'(pins[14]), 32'd1);

        // R2: reserved bits drop, defined fields keep their positions
        tag_pin[0] = "R9";
        step(1'b1, 32'hFEFE_FEFE, 16'h0);
        chk("R2", cfg_rdata, 32'h00FE_00FE);
        step(1'b1, 32'hFFFF_FFFF, 16'h0);
        chk("R2", cfg_rdata, 32'h01FF_01FF);

        // R9: independent channel 1 run while channel 0 stays off
        step(1'b1, word(0, 0, 0, 1, 2, 0), 16'h8000);
        repeat (12) step(1'b0, '0, 16'h4000);
        chk("R9", 32'(pins[14]), 32'd1);

        // R9 and R6: random writes colliding with boundaries on both channels
        for (int i = 0; i < 4000; i++) begin
            bit          wr;
            logic [31:0] wd;
            wr = (($urandom % 6) == 0);
            wd = $urandom;
            if (($urandom % 4) != 0) wd[8] = 1'b1;
            if (($urandom % 4) != 0) wd[24] = 1'b1;
            step(wr, wd, 16'($urandom));
        end
        compare_now();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule